// File: doc/BRIEF.md
# CRC-32 Word-Aligned Frame Builder and Verifier

This block sits between a byte-wide message source and a serial link, and between that link and a message consumer. It has two separate byte streams. In the send direction it passes the payload bytes through unchanged. It then adds zero bytes until the frame reaches a four-byte boundary. Last, it adds a four-byte CRC-32 check word, most significant byte first. In the receive direction it takes a complete frame and holds back the final four bytes as the check word. It runs the CRC over every earlier byte and gives exactly one verdict, at the moment the last byte is accepted.

The CRC is the reflected IEEE form. Each frame starts from all ones, and the result is inverted before it is sent or compared. A received frame that is too short to hold at least one payload word plus the check word is rejected as short, and no CRC verdict is given for it. Both streams use valid/ready handshakes and a last-byte marker. One byte moves per clock on each side.

Top module: `crc_frame_unit`

## Requirements
- R1: The check word is the reflected CRC-32 with polynomial 0xEDB88320, an all-ones start value and a bit-inverted result. For example, four zero bytes give 0x2144DF1C and the ASCII string "123456789" gives 0xCBF43926.
- R2: On the send side every payload byte appears on `tx_out_data` unchanged and in order, and each one is consumed only when the output handshake completes.
- R3: When the payload length is not a multiple of four, zero bytes follow the payload until the count is a multiple of four. When the length is already a multiple of four, no zero bytes are added.
- R4: The check word covers the payload and the padding. It follows them as four bytes, bits 31:24 first and bits 7:0 last, and `tx_out_last` is high only on the final check-word byte.
- R5: A sent frame is exactly the padded payload length plus four bytes, so it is never shorter than 8 bytes.
- R6: A received frame of fewer than 8 bytes raises `rx_short` and neither `rx_good` nor `rx_crc_err`.
- R7: For a received frame of 8 or more bytes, the CRC runs over all bytes except the last four. Those four are taken as a big-endian word, first byte in bits 31:24, and compared with the CRC. A match raises `rx_good` and a difference raises `rx_crc_err`.
- R8: The receive verdict is combinational and appears only in the cycle where a byte with `rx_last` is presented with `rx_valid`. In that cycle exactly one of `rx_good`, `rx_short` and `rx_crc_err` is high, and all three are low in every other cycle.
- R9: Both directions restart their CRC and byte count at each new frame, so frames sent back to back give the same results as frames sent alone.
- R10: While `tx_out_ready` is low, the send side holds its current output byte and its last marker, and it accepts no new payload byte.
- R11: After reset, `tx_out_valid` is low while no payload is offered, all receive verdict outputs are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Payload byte offered |
| tx_in_data | input | 8 | Payload byte |
| tx_in_last | input | 1 | Final payload byte of the message |
| tx_in_ready | output | 1 | Payload byte accepted this cycle |
| tx_out_valid | output | 1 | Framed byte offered to the link |
| tx_out_data | output | 8 | Framed byte (payload, padding or check word) |
| tx_out_last | output | 1 | Final check-word byte |
| tx_out_ready | input | 1 | Link accepts the framed byte |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Final byte of the received frame |
| rx_ready | output | 1 | Always high; the receiver takes a byte every cycle |
| rx_good | output | 1 | Frame verdict: check word matches |
| rx_short | output | 1 | Frame verdict: fewer than 8 bytes |
| rx_crc_err | output | 1 | Frame verdict: check word differs |

## Verification
Each receive verdict is combinational on the cycle that carries the last byte. The bench drives that byte after a falling edge, waits one time step, and reads the flags before the next rising edge. On the send side, each byte's handshake is decided inside a single clock period. The bench therefore sets `tx_out_ready` and the payload inputs just after the falling edge, and after a short settle records any byte whose valid and ready are both high, since that byte will transfer on the coming edge. The recorded stream is compared byte by byte with a frame built by a bench function. Random backpressure and idle gaps show that no result depends on a fixed latency.

// File: rtl/crcf_pkg.sv
package crcf_pkg;

    localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
    localparam int          WORD_BYTES = 4;

    typedef enum logic [1:0] {
        TX_BODY,
        TX_PAD,
        TX_TRAIL
    } tx_phase_e;

    typedef struct packed {
        logic good;
        logic too_short;
        logic crc_bad;
    } rx_verdict_t;

    // One byte through the reflected CRC register, eight shift steps.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/crcf_tx.sv
module crcf_tx
    import crcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);
    localparam int AW = $clog2(WORD_BYTES);

    tx_phase_e        phase_q;
    logic [31:0]      crc_q;
    logic [AW-1:0]    align_q;
    logic [AW-1:0]    trail_q;
    logic [31:0]      check_word;
    logic             xfer;

    localparam logic [AW-1:0] ALIGN_TOP = AW'(WORD_BYTES - 1);

    assign check_word = ~crc_q;
    assign xfer       = out_valid && out_ready;

    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        in_ready  = 1'b0;
        unique case (phase_q)
            TX_BODY: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
            end
            TX_PAD: begin
                out_valid = 1'b1;
            end
            default: begin
                out_valid = 1'b1;
                out_last  = (trail_q == ALIGN_TOP);
                case (trail_q)
                    2'd0:    out_data = check_word[31:24];
                    2'd1:    out_data = check_word[23:16];
                    2'd2:    out_data = check_word[15:8];
                    default: out_data = check_word[7:0];
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= TX_BODY;
            crc_q   <= CRC_SEED;
            align_q <= '0;
            trail_q <= '0;
        end else if (xfer) begin
            unique case (phase_q)
                TX_BODY: begin
                    crc_q   <= crc_step(crc_q, in_data);
                    align_q <= align_q + 1'b1;
                    if (in_last) begin
                        phase_q <= (align_q == ALIGN_TOP) ? TX_TRAIL : TX_PAD;
                    end
                end
                TX_PAD: begin
                    crc_q   <= crc_step(crc_q, 8'h00);
                    align_q <= align_q + 1'b1;
                    if (align_q == ALIGN_TOP) begin
                        phase_q <= TX_TRAIL;
                    end
                end
                default: begin
                    trail_q <= trail_q + 1'b1;
                    if (trail_q == ALIGN_TOP) begin
                        phase_q <= TX_BODY;
                        crc_q   <= CRC_SEED;
                        align_q <= '0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/crcf_rx.sv
module crcf_rx
    import crcf_pkg::*;
#(
    parameter int MIN_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output rx_verdict_t verdict
);
    localparam int CW = $clog2(MIN_BYTES + 1);
    localparam logic [CW-1:0] CNT_SAT   = CW'(MIN_BYTES);
    localparam logic [CW-1:0] CNT_SHORT = CW'(MIN_BYTES - 1);
    localparam logic [CW-1:0] CNT_WIN   = CW'(WORD_BYTES);

    logic [WORD_BYTES-1:0][7:0] win_q;
    logic [CW-1:0]              cnt_q;
    logic [31:0]                crc_q;
    logic [31:0]                crc_body;
    logic [31:0]                trailer;
    logic                       done;
    logic                       short_frame;
    logic                       match;

    // The oldest byte in the window belongs to the body once a fifth byte arrives.
    assign crc_body    = (cnt_q >= CNT_WIN) ? crc_step(crc_q, win_q[WORD_BYTES-1]) : crc_q;
    assign trailer     = {win_q[2], win_q[1], win_q[0], in_data};
    assign done        = in_valid && in_last;
    assign short_frame = cnt_q < CNT_SHORT;
    assign match       = (~crc_body) == trailer;

    always_comb begin
        verdict           = '0;
        verdict.too_short = done && short_frame;
        verdict.good      = done && !short_frame && match;
        verdict.crc_bad   = done && !short_frame && !match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cnt_q <= '0;
            crc_q <= CRC_SEED;
        end else if (in_valid) begin
            if (in_last) begin
                cnt_q <= '0;
                crc_q <= CRC_SEED;
            end else begin
                win_q <= {win_q[WORD_BYTES-2:0], in_data};
                crc_q <= crc_body;
                if (cnt_q != CNT_SAT) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/crc_frame_unit.sv
module crc_frame_unit
    import crcf_pkg::*;
#(
    parameter int MIN_FRAME_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_in_valid,
    input  logic [7:0] tx_in_data,
    input  logic       tx_in_last,
    output logic       tx_in_ready,
    output logic       tx_out_valid,
    output logic [7:0] tx_out_data,
    output logic       tx_out_last,
    input  logic       tx_out_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_last,
    output logic       rx_ready,
    output logic       rx_good,
    output logic       rx_short,
    output logic       rx_crc_err
);
    rx_verdict_t rx_verdict;

    crcf_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_in_valid),
        .in_data   (tx_in_data),
        .in_last   (tx_in_last),
        .in_ready  (tx_in_ready),
        .out_valid (tx_out_valid),
        .out_data  (tx_out_data),
        .out_last  (tx_out_last),
        .out_ready (tx_out_ready)
    );

    crcf_rx #(.MIN_BYTES(MIN_FRAME_BYTES)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_last  (rx_last),
        .verdict  (rx_verdict)
    );

    assign rx_ready   = 1'b1;
    assign rx_good    = rx_verdict.good;
    assign rx_short   = rx_verdict.too_short;
    assign rx_crc_err = rx_verdict.crc_bad;

endmodule

// File: rtl/crc_frame_unit_checker.sv
module crc_frame_unit_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_out_valid,
    input logic [7:0] tx_out_data,
    input logic       tx_out_last,
    input logic       tx_out_ready,
    input logic       rx_valid,
    input logic       rx_last,
    input logic       rx_good,
    input logic       rx_short,
    input logic       rx_crc_err
);
    logic [1:0] mod_q;
    logic [2:0] sat_q;
    logic       tx_xfer;

    assign tx_xfer = tx_out_valid && tx_out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_q <= '0;
            sat_q <= '0;
        end else if (tx_xfer) begin
            if (tx_out_last) begin
                mod_q <= '0;
                sat_q <= '0;
            end else begin
                mod_q <= mod_q + 1'b1;
                if (sat_q != 3'd7) sat_q <= sat_q + 1'b1;
            end
        end
    end

    AST_RX_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_last) |-> ($countones({rx_good, rx_short, rx_crc_err}) == 1)); // R8

    AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_last) |-> !(rx_good || rx_short || rx_crc_err)); // R8

    AST_TX_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (tx_xfer && tx_out_last) |-> (mod_q == 2'd3)); // R3

    AST_TX_MIN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (tx_xfer && tx_out_last) |-> (sat_q == 3'd7)); // R5

    AST_TX_HOLD_LAST: assert property (@(posedge clk) disable iff (rst)
        (tx_out_valid && !tx_out_ready && tx_out_last) |=>
            (tx_out_valid && tx_out_last && $stable(tx_out_data))); // R10

endmodule

bind crc_frame_unit crc_frame_unit_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_out_valid (tx_out_valid),
    .tx_out_data  (tx_out_data),
    .tx_out_last  (tx_out_last),
    .tx_out_ready (tx_out_ready),
    .rx_valid     (rx_valid),
    .rx_last      (rx_last),
    .rx_good      (rx_good),
    .rx_short     (rx_short),
    .rx_crc_err   (rx_crc_err)
);

// File: tb/crc_frame_unit_test.sv
module crc_frame_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_in_valid = 1'b0;
    logic [7:0] tx_in_data = 8'h00;
    logic       tx_in_last = 1'b0;
    logic       tx_in_ready;
    logic       tx_out_valid;
    logic [7:0] tx_out_data;
    logic       tx_out_last;
    logic       tx_out_ready = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_last = 1'b0;
    logic       rx_ready;
    logic       rx_good;
    logic       rx_short;
    logic       rx_crc_err;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [7:0] msg [0:63];
    logic [7:0] got [0:63];
    logic       got_last [0:63];

    localparam int KIND_GOOD = 0;
    localparam int KIND_SHORT = 1;
    localparam int KIND_BAD = 2;

    always #4 clk = ~clk;

    crc_frame_unit uut (
        .clk (clk), .rst (rst),
        .tx_in_valid (tx_in_valid), .tx_in_data (tx_in_data), .tx_in_last (tx_in_last),
        .tx_in_ready (tx_in_ready),
        .tx_out_valid (tx_out_valid), .tx_out_data (tx_out_data), .tx_out_last (tx_out_last),
        .tx_out_ready (tx_out_ready),
        .rx_valid (rx_valid), .rx_data (rx_data), .rx_last (rx_last), .rx_ready (rx_ready),
        .rx_good (rx_good), .rx_short (rx_short), .rx_crc_err (rx_crc_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit-serial reference over msg[0..n-1].
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ msg[i][k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    // Send msg[0..n-1]; compare the framed output with the expected frame.
    task automatic tx_frame(input int n, input int stall_pct);
        int idx = 0;
        int cnt = 0;
        bit done = 1'b0;
        int pad;
        int total;
        logic [31:0] crc;
        pad = (4 - (n % 4)) % 4;
        for (int i = n; i < n + pad; i++) msg[i] = 8'h00;
        crc = ref_crc(n + pad);
        total = n + pad + 4;
        while (!done) begin
            @(negedge clk);
            tx_in_valid  = (idx < n);
            tx_in_data   = (idx < n) ? msg[idx] : 8'h00;
            tx_in_last   = (idx == n - 1);
            tx_out_ready = (($urandom % 100) >= stall_pct);
            #1;
            if (tx_in_valid && tx_in_ready) idx++;
            if (tx_out_valid && tx_out_ready && cnt < 64) begin
                got[cnt] = tx_out_data;
                got_last[cnt] = tx_out_last;
                cnt++;
                if (tx_out_last) done = 1'b1;
            end
        end
        @(negedge clk);
        tx_in_valid = 1'b0;
        tx_in_last = 1'b0;
        tx_out_ready = 1'b1;
        check(cnt == total, "R5 frame length", cnt, total);
        for (int i = 0; i < cnt && i < total; i++) begin
            logic [7:0] e;
            if (i < n + pad) e = msg[i];
            else e = crc[8*(total-1-i) +: 8];
            if (i < n)            check(got[i] == e, "R2 payload byte", {24'h0, got[i]}, {24'h0, e});
            else if (i < n + pad) check(got[i] == e, "R3 pad byte", {24'h0, got[i]}, {24'h0, e});
            else                  check(got[i] == e, "R4 check byte", {24'h0, got[i]}, {24'h0, e});
            check(got_last[i] == (i == total - 1), "R4 last marker", {31'h0, got_last[i]}, {31'h0, (i == total - 1)});
        end
    endtask

    // Present msg[0..n-1] as a received frame and check the verdict.
    task automatic rx_frame(input int n, input int kind, input int gap_pct, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (($urandom % 100) < gap_pct) begin
                rx_valid = 1'b0;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_data  = msg[i];
            rx_last  = (i == n - 1);
            #1;
            if (i < n - 1) begin
                if (rx_good || rx_short || rx_crc_err) begin
                    check(1'b0, "R8 flags outside last byte", {29'h0, rx_good, rx_short, rx_crc_err}, 32'h0);
                end
            end else begin
                logic [2:0] exp;
                exp = (kind == KIND_GOOD) ? 3'b100 : (kind == KIND_SHORT) ? 3'b010 : 3'b001;
                check({rx_good, rx_short, rx_crc_err} == exp, req,
                      {29'h0, rx_good, rx_short, rx_crc_err}, {29'h0, exp});
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last = 1'b0;
        #1;
        check(!(rx_good || rx_short || rx_crc_err), "R8 flags after frame",
              {29'h0, rx_good, rx_short, rx_crc_err}, 32'h0);
    endtask

    // Build a well-formed received frame of n body bytes in msg.
    task automatic build_rx(input int n);
        logic [31:0] c;
        c = ref_crc(n);
        for (int i = 0; i < 4; i++) msg[n + i] = c[8*(3-i) +: 8];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(tx_out_valid == 1'b0, "R11 reset tx_out_valid", {31'h0, tx_out_valid}, 32'h0);
        check({rx_good, rx_short, rx_crc_err} == 3'b000, "R11 reset verdict",
              {29'h0, rx_good, rx_short, rx_crc_err}, 32'h0);
        check(rx_ready == 1'b1, "R11 reset rx_ready", {31'h0, rx_ready}, 32'h1);

        // R1 known values of the bench reference
        for (int i = 0; i < 4; i++) msg[i] = 8'h00;
        check(ref_crc(4) == 32'h2144DF1C, "R1 zero-word constant", ref_crc(4), 32'h2144DF1C);

        // R3 R5: single 0x00 byte pads to four and gives an 8-byte frame
        msg[0] = 8'h00;
        tx_frame(1, 0);
        check({got[4], got[5], got[6], got[7]} == 32'h2144DF1C, "R1 single zero byte trailer",
              {got[4], got[5], got[6], got[7]}, 32'h2144DF1C);

        // R3: length already aligned, no padding
        for (int i = 0; i < 8; i++) msg[i] = 8'(8'h11 * i);
        tx_frame(8, 0);

        // R9: back-to-back sends and random lengths under backpressure (R10)
        for (int t = 0; t < 30; t++) begin
            int n;
            n = 1 + ($urandom % 40);
            for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
            tx_frame(n, (t % 3) * 30);
        end

        // R1: receive the standard check string with its CRC
        for (int i = 0; i < 9; i++) msg[i] = 8'(8'h31 + i);
        msg[9] = 8'hCB; msg[10] = 8'hF4; msg[11] = 8'h39; msg[12] = 8'h26;
        rx_frame(13, KIND_GOOD, 0, "R1 check string verdict");

        // R7: exactly 8 bytes, good and corrupted
        for (int i = 0; i < 4; i++) msg[i] = 8'(8'hA0 + i);
        build_rx(4);
        rx_frame(8, KIND_GOOD, 0, "R7 eight-byte good frame");
        msg[7] = msg[7] ^ 8'h01;
        rx_frame(8, KIND_BAD, 0, "R7 eight-byte corrupt trailer");

        // R6: all lengths below eight are short, even if the tail looks right
        for (int n = 1; n < 8; n++) begin
            for (int i = 0; i < n; i++) msg[i] = 8'h00;
            if (n >= 5) build_rx(n - 4);
            rx_frame(n, KIND_SHORT, 0, "R6 short frame");
        end

        // R7 R9: random good and corrupted frames with idle gaps
        for (int t = 0; t < 40; t++) begin
            int n;
            int pos;
            n = 4 + ($urandom % 40);
            for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
            build_rx(n);
            if (t % 2 == 1) begin
                pos = $urandom % (n + 4);
                msg[pos] = msg[pos] ^ 8'(1 << ($urandom % 8));
                rx_frame(n + 4, KIND_BAD, 25, "R7 corrupted frame");
            end else begin
                rx_frame(n + 4, KIND_GOOD, (t % 4 == 0) ? 0 : 25, "R9 good frame after previous");
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule